// File: doc/BRIEF.md
# CEC Transmit Frame Stager with Retry Control

This block keeps one outgoing CEC frame that a host assembles over a simple register port: the initiator and destination logical addresses, an opcode and up to `MAX_OPS` operand bytes. A write to the start register, carrying the operand count, hands the staged frame to a line engine through a request/done/ack handshake. If the engine reports that nobody acknowledged, the controller requests the frame again, up to a programmable number of extra attempts. A header-only polling frame is started by the destination write itself, because no start write follows.

The outcome is reported in two separate write-one-to-clear status bits, one for success and one for running out of retries. Each bit raises the interrupt output only when its enable bit is set. A self-clearing buffer-clear control empties the staged frame and aborts any transaction in progress without raising either outcome.

The controller is a three-state machine. In IDLE it waits for a start. Taking the *launch* transition moves it to REQUEST, where `le_req` is held high until `le_done`. In REQUEST, *acknowledged* returns to IDLE and sets the success bit. *Exhausted* is a no-acknowledge with no retries left: it returns to IDLE and sets the retry-exhausted bit. *Retry* is a no-acknowledge with retries left: it moves to BACKOFF and uses up one retry. From BACKOFF, *relaunch* returns to REQUEST after one cycle with the request low. *Abort* is the buffer clear, which sends any state to IDLE.

Top module: `cec_tx_stager`

## Requirements
- R1: After reset every register reads zero, and `le_req`, `irq` and the busy flag (bit 0 at 0x0C) are 0.
- R2: Writing 0x20 with bit 4 set while idle starts a transaction in the next cycle, and the count in bits 3:0 is clamped to `MAX_OPS`. The busy flag reads 1 from the start until the outcome. The frame fields (initiator at 0x00 bits 3:0, destination at 0x04 bits 3:0, opcode at 0x08) appear on the `le_*` outputs.
- R3: Operand n is written at address 0x40 + 4·n and appears on byte n of `le_operands`.
- R4: Writing 0x04 with bit 7 set while idle starts a polling frame at once, with `le_poll` = 1 and `le_opcount` = 0.
- R5: Bits 6:4 at 0x0C hold the retry count, which is the number of attempts minus one. Each no-acknowledge with retries left drops `le_req` for at least one cycle and requests again. The register at 0x24 reads the number of attempts made in the last transaction.
- R6: An acknowledged attempt ends the transaction, sets bit 5 at 0x10, and leads to no further request.
- R7: When every one of retry+1 attempts is refused, bit 1 at 0x14 is set and bit 5 at 0x10 stays clear.
- R8: Writing 1 to bit 5 of 0x10 or bit 1 of 0x14 clears that bit, and writing 0 leaves it unchanged.
- R9: `irq` is high exactly when a status bit is set together with its enable: bit 5 at 0x18 for success, bit 1 at 0x1C for exhaustion.
- R10: While busy, start writes, polling destination writes and writes to the frame and retry fields are ignored.
- R11: Writing bit 7 of 0x0C aborts any transaction, drops `le_req` and zeroes the frame fields and the count, and raises no status. The bit reads 1 until the clear has finished and then reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Register byte address |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Interrupt, status ANDed with enables |
| le_req | output | 1 | Request to the line engine to send the frame |
| le_done | input | 1 | Line engine attempt finished (one-cycle pulse) |
| le_ack | input | 1 | Attempt was acknowledged, valid with le_done |
| le_poll | output | 1 | Frame is header-only |
| le_initiator | output | 4 | Initiator logical address |
| le_dest | output | 4 | Destination logical address |
| le_opcode | output | 8 | Opcode byte |
| le_opcount | output | $clog2(MAX_OPS+1) | Number of operand bytes |
| le_operands | output | MAX_OPS*8 | Operand bytes, operand n at bits 8n+7:8n |

## Verification
The bench goes after the retry arithmetic at its edges. A retry count of zero must give exactly one attempt, and an acknowledge on a late attempt must stop the retries there. An off-by-one counter would show one request too many or too few and a wrong attempt count. It starts again while busy and checks that the engine sees neither a fresh opcode nor a restart; a design that re-launched would show extra requests. It aborts a transaction that never completes and checks that the request drops, the staged bytes read zero and no status appears. A count above the limit must be clamped, and a polling frame must start from the destination write alone.

// File: rtl/cec_tx_pkg.sv
package cec_tx_pkg;

    localparam int RETRY_W = 3;            // retry field width at CTRL[6:4]
    localparam int ATT_W   = RETRY_W + 1;  // attempts 1..2**RETRY_W

    localparam logic [7:0] A_INIT  = 8'h00;
    localparam logic [7:0] A_DEST  = 8'h04;
    localparam logic [7:0] A_OPC   = 8'h08;
    localparam logic [7:0] A_CTRL  = 8'h0C;
    localparam logic [7:0] A_ST0   = 8'h10;
    localparam logic [7:0] A_ST1   = 8'h14;
    localparam logic [7:0] A_EN0   = 8'h18;
    localparam logic [7:0] A_EN1   = 8'h1C;
    localparam logic [7:0] A_START = 8'h20;
    localparam logic [7:0] A_ATT   = 8'h24;
    localparam logic [7:0] A_OPND  = 8'h40;

    typedef enum logic [1:0] {
        S_IDLE,
        S_REQUEST,
        S_BACKOFF
    } tx_state_t;

endpackage

// File: rtl/cec_tx_fsm.sv
module cec_tx_fsm
    import cec_tx_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               start,
    input  logic               clr,
    input  logic [RETRY_W-1:0] retry_cfg,
    input  logic               le_done,
    input  logic               le_ack,
    output logic               le_req,
    output logic               busy,
    output logic               ok_pulse,
    output logic               exh_pulse,
    output logic [ATT_W-1:0]   attempts
);

    tx_state_t          state_q, state_d;
    logic [RETRY_W-1:0] left_q;
    logic               launch, finish, no_left;

    assign no_left = (left_q == '0);
    assign launch  = (state_q == S_IDLE) && start && !clr;
    assign finish  = (state_q == S_REQUEST) && le_done && !clr;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            S_IDLE:    if (start) state_d = S_REQUEST;
            S_REQUEST: if (le_done) state_d = (le_ack || no_left) ? S_IDLE : S_BACKOFF;
            S_BACKOFF: state_d = S_REQUEST;
            default:   state_d = S_IDLE;
        endcase
        if (clr) state_d = S_IDLE;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= S_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        le_req    = (state_q == S_REQUEST);
        busy      = (state_q != S_IDLE);
        ok_pulse  = finish && le_ack;
        exh_pulse = finish && !le_ack && no_left;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            left_q   <= '0;
            attempts <= '0;
        end else if (launch) begin
            left_q   <= retry_cfg;
            attempts <= ATT_W'(1);
        end else if (finish && !le_ack && !no_left) begin
            left_q   <= left_q - 1'b1;
        end else if (state_q == S_BACKOFF && !clr) begin
            attempts <= attempts + 1'b1;
        end
    end

endmodule

// File: rtl/cec_tx_regs.sv
module cec_tx_regs
    import cec_tx_pkg::*;
#(
    parameter int MAX_OPS = 14,
    parameter int CNT_W   = 4
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 reg_wr,
    input  logic [7:0]           reg_addr,
    input  logic [7:0]           reg_wdata,
    output logic [7:0]           reg_rdata,
    input  logic                 busy,
    input  logic                 ok_pulse,
    input  logic                 exh_pulse,
    input  logic [ATT_W-1:0]     attempts,
    output logic                 start,
    output logic                 clr,
    output logic [RETRY_W-1:0]   retry_cfg,
    output logic                 st_ok,
    output logic                 st_exh,
    output logic                 en_ok,
    output logic                 en_exh,
    output logic                 le_poll,
    output logic [3:0]           le_initiator,
    output logic [3:0]           le_dest,
    output logic [7:0]           le_opcode,
    output logic [CNT_W-1:0]     le_opcount,
    output logic [MAX_OPS*8-1:0] le_operands
);

    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_OPS);

    logic [3:0]           init_q, dest_q;
    logic                 poll_q;
    logic [7:0]           opc_q;
    logic [CNT_W-1:0]     cnt_q, cnt_wr;
    logic [MAX_OPS*8-1:0] opnd_q;
    logic [MAX_OPS-1:0]   opnd_hit;
    logic                 stage_wr;

    assign stage_wr = reg_wr && !busy;
    assign cnt_wr   = (int'(reg_wdata[3:0]) > MAX_OPS) ? CNT_MAX : CNT_W'(reg_wdata[3:0]);
    assign start    = stage_wr && (((reg_addr == A_START) && reg_wdata[4]) ||
                                   ((reg_addr == A_DEST)  && reg_wdata[7]));

    for (genvar g = 0; g < MAX_OPS; g++) begin : g_opnd_dec
        assign opnd_hit[g] = (reg_addr == (A_OPND + 8'(4 * g)));
    end

    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            init_q <= '0;
            dest_q <= '0;
            poll_q <= 1'b0;
            opc_q  <= '0;
            cnt_q  <= '0;
            opnd_q <= '0;
        end else if (stage_wr) begin
            case (reg_addr)
                A_INIT:  init_q <= reg_wdata[3:0];
                A_DEST:  begin
                    dest_q <= reg_wdata[3:0];
                    poll_q <= reg_wdata[7];
                end
                A_OPC:   opc_q <= reg_wdata;
                A_START: if (reg_wdata[4]) cnt_q <= cnt_wr;
                default: begin
                    for (int i = 0; i < MAX_OPS; i++)
                        if (opnd_hit[i]) opnd_q[i*8 +: 8] <= reg_wdata;
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            retry_cfg <= '0;
            clr       <= 1'b0;
        end else begin
            if (clr)
                clr <= 1'b0;
            else if (reg_wr && reg_addr == A_CTRL && reg_wdata[7])
                clr <= 1'b1;
            if (stage_wr && reg_addr == A_CTRL)
                retry_cfg <= reg_wdata[6:4];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_ok  <= 1'b0;
            st_exh <= 1'b0;
            en_ok  <= 1'b0;
            en_exh <= 1'b0;
        end else begin
            if (ok_pulse)                                        st_ok  <= 1'b1;
            else if (reg_wr && reg_addr == A_ST0 && reg_wdata[5]) st_ok  <= 1'b0;
            if (exh_pulse)                                       st_exh <= 1'b1;
            else if (reg_wr && reg_addr == A_ST1 && reg_wdata[1]) st_exh <= 1'b0;
            if (reg_wr && reg_addr == A_EN0) en_ok  <= reg_wdata[5];
            if (reg_wr && reg_addr == A_EN1) en_exh <= reg_wdata[1];
        end
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            A_INIT:  reg_rdata = {4'b0, init_q};
            A_DEST:  reg_rdata = {poll_q, 3'b0, dest_q};
            A_OPC:   reg_rdata = opc_q;
            A_CTRL:  reg_rdata = {clr, retry_cfg, 3'b0, busy};
            A_ST0:   reg_rdata = {2'b0, st_ok, 5'b0};
            A_ST1:   reg_rdata = {6'b0, st_exh, 1'b0};
            A_EN0:   reg_rdata = {2'b0, en_ok, 5'b0};
            A_EN1:   reg_rdata = {6'b0, en_exh, 1'b0};
            A_START: reg_rdata = 8'(cnt_q);
            A_ATT:   reg_rdata = 8'(attempts);
            default: begin
                for (int i = 0; i < MAX_OPS; i++)
                    if (opnd_hit[i]) reg_rdata = opnd_q[i*8 +: 8];
            end
        endcase
    end

    assign le_poll      = poll_q;
    assign le_initiator = init_q;
    assign le_dest      = dest_q;
    assign le_opcode    = opc_q;
    assign le_opcount   = poll_q ? '0 : cnt_q;
    assign le_operands  = opnd_q;

endmodule

// File: rtl/cec_tx_stager.sv
module cec_tx_stager
    import cec_tx_pkg::*;
#(
    parameter int MAX_OPS = 14
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         reg_wr,
    input  logic [7:0]                   reg_addr,
    input  logic [7:0]                   reg_wdata,
    output logic [7:0]                   reg_rdata,
    output logic                         irq,
    output logic                         le_req,
    input  logic                         le_done,
    input  logic                         le_ack,
    output logic                         le_poll,
    output logic [3:0]                   le_initiator,
    output logic [3:0]                   le_dest,
    output logic [7:0]                   le_opcode,
    output logic [$clog2(MAX_OPS+1)-1:0] le_opcount,
    output logic [MAX_OPS*8-1:0]         le_operands
);

    localparam int CNT_W = $clog2(MAX_OPS + 1);

    logic               busy_w, ok_w, exh_w, start_w, clr_w;
    logic               st_ok_w, st_exh_w, en_ok_w, en_exh_w;
    logic [RETRY_W-1:0] retry_w;
    logic [ATT_W-1:0]   att_w;

    cec_tx_regs #(.MAX_OPS(MAX_OPS), .CNT_W(CNT_W)) u_regs (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .busy         (busy_w),
        .ok_pulse     (ok_w),
        .exh_pulse    (exh_w),
        .attempts     (att_w),
        .start        (start_w),
        .clr          (clr_w),
        .retry_cfg    (retry_w),
        .st_ok        (st_ok_w),
        .st_exh       (st_exh_w),
        .en_ok        (en_ok_w),
        .en_exh       (en_exh_w),
        .le_poll      (le_poll),
        .le_initiator (le_initiator),
        .le_dest      (le_dest),
        .le_opcode    (le_opcode),
        .le_opcount   (le_opcount),
        .le_operands  (le_operands)
    );

    cec_tx_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .start     (start_w),
        .clr       (clr_w),
        .retry_cfg (retry_w),
        .le_done   (le_done),
        .le_ack    (le_ack),
        .le_req    (le_req),
        .busy      (busy_w),
        .ok_pulse  (ok_w),
        .exh_pulse (exh_w),
        .attempts  (att_w)
    );

    assign irq = (st_ok_w && en_ok_w) || (st_exh_w && en_exh_w);

endmodule

// File: rtl/cec_tx_checker.sv
module cec_tx_checker (
    input logic       clk,
    input logic       rst_n,
    input logic       le_req,
    input logic       le_done,
    input logic       busy,
    input logic       clr,
    input logic       ok_pulse,
    input logic       exh_pulse,
    input logic       st_ok,
    input logic       st_exh,
    input logic [7:0] le_opcode,
    input logic [3:0] le_dest
);

    assert_req_needs_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
        le_req |-> busy);

    assert_release_after_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (le_req && le_done) |=> !le_req);

    assert_success_sets_status_R6: assert property (@(posedge clk) disable iff (!rst_n)
        ok_pulse |=> st_ok);

    assert_exhaust_sets_status_R7: assert property (@(posedge clk) disable iff (!rst_n)
        exh_pulse |=> st_exh);

    assert_single_outcome_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ok_pulse, exh_pulse}));

    assert_frame_stable_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (le_req && !clr) |=> ($stable(le_opcode) && $stable(le_dest)));

    assert_abort_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (!busy && !le_req));

    assert_abort_silent_R11: assert property (@(posedge clk) disable iff (!rst_n)
        clr |-> (!ok_pulse && !exh_pulse));

endmodule

bind cec_tx_stager cec_tx_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .le_req    (le_req),
    .le_done   (le_done),
    .busy      (busy_w),
    .clr       (clr_w),
    .ok_pulse  (ok_w),
    .exh_pulse (exh_w),
    .st_ok     (st_ok_w),
    .st_exh    (st_exh_w),
    .le_opcode (le_opcode),
    .le_dest   (le_dest)
);

// File: tb/test_cec_tx_stager.sv
module test_cec_tx_stager;

    localparam int CLK_PERIOD = 10;
    localparam int MAX_OPS    = 14;
    localparam int CNT_W      = $clog2(MAX_OPS + 1);

    logic                 clk = 1'b0;
    logic                 rst_n = 1'b0;
    logic                 reg_wr = 1'b0;
    logic [7:0]           reg_addr = '0;
    logic [7:0]           reg_wdata = '0;
    logic [7:0]           reg_rdata;
    logic                 irq;
    logic                 le_req;
    logic                 le_done = 1'b0;
    logic                 le_ack = 1'b0;
    logic                 le_poll;
    logic [3:0]           le_initiator;
    logic [3:0]           le_dest;
    logic [7:0]           le_opcode;
    logic [CNT_W-1:0]     le_opcount;
    logic [MAX_OPS*8-1:0] le_operands;

    int n_chk = 0;
    int n_bad = 0;
    int eng_delay = 3;
    int ack_from = 0;
    int ack_base = 0;
    int done_total = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    cec_tx_stager #(.MAX_OPS(MAX_OPS)) i_cec_tx_stager (
        .clk          (clk),
        .rst_n        (rst_n),
        .reg_wr       (reg_wr),
        .reg_addr     (reg_addr),
        .reg_wdata    (reg_wdata),
        .reg_rdata    (reg_rdata),
        .irq          (irq),
        .le_req       (le_req),
        .le_done      (le_done),
        .le_ack       (le_ack),
        .le_poll      (le_poll),
        .le_initiator (le_initiator),
        .le_dest      (le_dest),
        .le_opcode    (le_opcode),
        .le_opcount   (le_opcount),
        .le_operands  (le_operands)
    );

    // line engine model: answers after eng_delay cycles of request
    initial begin
        int wcnt = 0;
        forever begin
            @(negedge clk);
            le_done = 1'b0;
            le_ack  = 1'b0;
            if (!le_req) wcnt = 0;
            else begin
                wcnt++;
                if (wcnt == eng_delay) begin
                    le_done = 1'b1;
                    le_ack  = ((done_total - ack_base) >= ack_from);
                    done_total++;
                end
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic wait_idle();
        logic [7:0] v;
        for (int i = 0; i < 3000; i++) begin
            rd(8'h0C, v);
            if (!v[0]) return;
        end
        check("R2 busy never cleared", 1, 0);
    endtask

    task automatic finish_up();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    task automatic t_reset();
        logic [7:0] v;
        rd(8'h0C, v); check("R1 ctrl", v, 0);
        rd(8'h10, v); check("R1 st0", v, 0);
        rd(8'h14, v); check("R1 st1", v, 0);
        rd(8'h24, v); check("R1 attempts", v, 0);
        check("R1 le_req", le_req, 0);
        check("R1 irq", irq, 0);
    endtask

    task automatic t_success();
        logic [7:0] v;
        int base;
        eng_delay = 3; ack_from = 0; ack_base = done_total; base = done_total;
        wr(8'h00, 8'h04); wr(8'h04, 8'h00); wr(8'h08, 8'h36);
        wr(8'h40, 8'hA1); wr(8'h44, 8'hB2); wr(8'h48, 8'hC3);
        wr(8'h0C, 8'h20); wr(8'h18, 8'h20);
        wr(8'h20, 8'h13);
        check("R2 le_req after start", le_req, 1);
        check("R2 opcode", le_opcode, 8'h36);
        check("R2 initiator", le_initiator, 4);
        check("R2 opcount", le_opcount, 3);
        check("R3 operand1", le_operands[15:8], 8'hB2);
        check("R3 operand2", le_operands[23:16], 8'hC3);
        rd(8'h0C, v); check("R2 busy flag", v[0], 1);
        wait_idle();
        check("R6 one request", done_total - base, 1);
        rd(8'h10, v); check("R6 success bit", v, 8'h20);
        rd(8'h14, v); check("R6 no exhaust", v, 0);
        rd(8'h24, v); check("R5 attempts", v, 1);
        check("R9 irq on", irq, 1);
        wr(8'h10, 8'h00); rd(8'h10, v); check("R8 write0 keeps", v, 8'h20);
        wr(8'h10, 8'h20); rd(8'h10, v); check("R8 w1c", v, 0);
        check("R9 irq off", irq, 0);
    endtask

    task automatic t_exhaust(input logic [2:0] retry, input bit en);
        logic [7:0] v;
        int base;
        eng_delay = 2; ack_from = 99; ack_base = done_total; base = done_total;
        wr(8'h1C, en ? 8'h02 : 8'h00);
        wr(8'h0C, {1'b0, retry, 4'b0});
        wr(8'h20, 8'h10);
        wait_idle();
        check("R7 attempts seen", done_total - base, int'(retry) + 1);
        rd(8'h24, v); check("R5 attempts reg", v, int'(retry) + 1);
        rd(8'h14, v); check("R7 exhaust bit", v, 8'h02);
        rd(8'h10, v); check("R7 no success", v, 0);
        check("R9 irq gated", irq, int'(en));
        if (!en) begin
            wr(8'h1C, 8'h02); check("R9 irq after enable", irq, 1);
        end
        wr(8'h14, 8'h02); rd(8'h14, v); check("R8 w1c st1", v, 0);
    endtask

    task automatic t_late_ack();
        logic [7:0] v;
        int base;
        eng_delay = 2; ack_from = 2; ack_base = done_total; base = done_total;
        wr(8'h0C, 8'h30);
        wr(8'h20, 8'h10);
        wait_idle();
        repeat (5) @(negedge clk);
        check("R5 stops at ack", done_total - base, 3);
        rd(8'h24, v); check("R5 attempts", v, 3);
        rd(8'h10, v); check("R6 success", v, 8'h20);
        wr(8'h10, 8'h20);
    endtask

    task automatic t_poll();
        logic [7:0] v;
        eng_delay = 2; ack_from = 0; ack_base = done_total;
        wr(8'h04, 8'h85);
        check("R4 req", le_req, 1);
        check("R4 poll", le_poll, 1);
        check("R4 opcount", le_opcount, 0);
        check("R4 dest", le_dest, 5);
        wait_idle();
        rd(8'h10, v); check("R4 success", v, 8'h20);
        wr(8'h10, 8'h20);
        wr(8'h04, 8'h00);
    endtask

    task automatic t_busy_ignore();
        logic [7:0] v;
        int base;
        eng_delay = 20; ack_from = 99; ack_base = done_total; base = done_total;
        wr(8'h08, 8'h44); wr(8'h0C, 8'h10);
        wr(8'h20, 8'h12);
        wr(8'h08, 8'h99);
        wr(8'h20, 8'h15);
        wr(8'h0C, 8'h70);
        check("R10 opcode held", le_opcode, 8'h44);
        check("R10 count held", le_opcount, 2);
        wait_idle();
        check("R10 no restart", done_total - base, 2);
        rd(8'h08, v); check("R10 opcode reg", v, 8'h44);
        rd(8'h0C, v); check("R10 retry held", v, 8'h10);
        wr(8'h14, 8'h02);
        eng_delay = 2; ack_from = 0; ack_base = done_total;
        wr(8'h20, 8'h1F);
        check("R2 clamp", le_opcount, MAX_OPS);
        wait_idle();
        wr(8'h10, 8'h20);
    endtask

    task automatic t_clear();
        logic [7:0] v;
        eng_delay = 1000; ack_from = 0; ack_base = done_total;
        wr(8'h08, 8'h77); wr(8'h40, 8'hAA);
        wr(8'h20, 8'h11);
        check("R11 req before", le_req, 1);
        wr(8'h0C, 8'h80);
        for (int i = 0; i < 10; i++) begin
            rd(8'h0C, v);
            if (!v[7]) break;
        end
        check("R11 self clear", v[7], 0);
        check("R11 not busy", v[0], 0);
        check("R11 req dropped", le_req, 0);
        repeat (20) @(negedge clk);
        rd(8'h10, v); check("R11 no success", v, 0);
        rd(8'h14, v); check("R11 no exhaust", v, 0);
        rd(8'h08, v); check("R11 opcode zero", v, 0);
        rd(8'h40, v); check("R11 operand zero", v, 0);
        check("R11 count zero", le_opcount, 0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_success();
        t_exhaust(3'd2, 1'b1);
        t_exhaust(3'd0, 1'b0);
        t_late_ack();
        t_poll();
        t_busy_ignore();
        t_clear();
        finish_up();
    end

endmodule